// File: doc/BRIEF.md
# Audio Clock Frequency Meter

This block measures the rate of one or more free-running audio clocks that are asynchronous to the system clock. Each measured clock drives a small divider in its own domain. One bit of that divider is resynchronised into the reference domain, and its transitions are counted there. A measurement window spans 128 prescaled cycles of the measured clock. The number of reference cycles that pass during the window is the result. Software recovers the frequency as f_ref × 128 × prescale / count.

Each channel chooses its prescale (1, 2 or 4) by itself. The choice uses a programmable boundary count, so the 10-bit result keeps a usable resolution across a wide frequency range. A channel also reports whether the result lies inside a programmable validity limit, and whether successive windows agree. A clock that stops is caught when the reference count saturates. Software reaches the thresholds and the per-channel results through a byte-wide register port.

Top module: `audio_clk_meter`

## Requirements
- R1: After reset, the boundary threshold reads 200 (address 0 = 0xC8, address 1 = 0x00). The validity threshold reads 1000 (address 2 = 0xE8, address 3 = 0x03). Each channel's count byte and status byte read 0.
- R2: The boundary threshold is 9 bits: the low byte is at address 0 and bit 8 is in bit 0 of address 1. The validity threshold is 10 bits: the low byte is at address 2 and bits 9:8 are in bits 1:0 of address 3. Written bits outside these fields read back as 0.
- R3: Channel c reports its count at address 4+2c (bits 7:0) and in bits 1:0 of address 5+2c (bits 9:8). In steady state the count is within ±1 of 128 × prescale × T_meas / T_ref.
- R4: In the status byte at address 5+2c, bits 3:2 read 0, bit 4 marks divide-by-2 and bit 5 marks divide-by-4, and no more than one of bits 5:4 is set. Software gives divide-by-4 priority if it ever sees both.
- R5: After a completed window, the prescale steps up one level (1→2→4) if the count is below the boundary threshold. It steps down one level (4→2→1) if the count exceeds twice the boundary. Otherwise it holds.
- R6: Status bit 6 (valid) is 1 when the last window completed with a nonzero count no greater than the validity threshold, and 0 otherwise.
- R7: If the reference count reaches 1023 before the window completes, the window ends with count 1023, valid 0 and stable 0. The prescale then rotates 1→4, 2→1, 4→2.
- R8: Status bit 7 (stable) is 1 when the last two windows both completed at the same prescale with counts that differ by at most 2. A prescale change between the two windows clears it.
- R9: Count and status change only at the end of a window, and they change in the same cycle.
- R10: Channels are independent: a missing clock on one channel leaves the other channel's results unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| meas_clk_i | input | NUM_CH | Measured audio clocks, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational from addr_i) |

## Verification
The bench builds the block with its default parameters: two channels, a 10-bit count, a 128-cycle window and a 9-bit boundary. The 20 ns reference makes the steady counts of measured periods between 10 ns and 150 ns easy to state, and that range reaches all three prescale levels. It also reaches the step-up and step-down paths, the timeout rotation out of an aliased divide-by-1 state, and a ratio with a fraction where successive counts alternate. Measured edges are offset from reference edges, so expected counts follow directly from the period ratio. Exact-ratio points let the validity threshold be placed on the count itself and one below it.

// File: rtl/acm_pkg.sv
`timescale 1ns/1ps
package acm_pkg;
  typedef enum logic [1:0] {
    PS_DIV1 = 2'd0,
    PS_DIV2 = 2'd1,
    PS_DIV4 = 2'd2
  } ps_e;

  localparam int PS_NUM = 3;
endpackage

// File: rtl/acm_meas_div.sv
`timescale 1ns/1ps
// Free-running binary divider in the measured-clock domain; bit k toggles every 2^k cycles.
module acm_meas_div #(
  parameter int W = 3
) (
  input  logic         meas_clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] tog_o
);
  always_ff @(posedge meas_clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_o <= '0;
    else         tog_o <= tog_o + 1'b1;
  end
endmodule

// File: rtl/acm_sync.sv
`timescale 1ns/1ps
module acm_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/acm_window.sv
`timescale 1ns/1ps
// Counts reference cycles over 2^WIN_LOG2 transitions of the selected toggle bit.
module acm_window
  import acm_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int WIN_LOG2 = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PS_NUM-1:0] tog_i,
  input  ps_e               ps_i,
  output logic              done_o,
  output logic              tmo_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [PS_NUM-1:0]   tog_q;
  logic [WIN_LOG2-1:0] edge_q;
  logic [CNT_W-1:0]    ref_q;
  logic                hit;

  always_comb begin
    case (ps_i)
      PS_DIV2: hit = tog_i[1] ^ tog_q[1];
      PS_DIV4: hit = tog_i[2] ^ tog_q[2];
      default: hit = tog_i[0] ^ tog_q[0];
    endcase
  end

  assign tmo_o  = &ref_q;
  assign done_o = tmo_o | (hit & (&edge_q));
  assign cnt_o  = tmo_o ? '1 : ref_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_q  <= '0;
      edge_q <= '0;
      ref_q  <= '0;
    end else begin
      tog_q <= tog_i;
      if (done_o) begin
        edge_q <= '0;
        ref_q  <= '0;
      end else begin
        edge_q <= edge_q + {{(WIN_LOG2-1){1'b0}}, hit};
        ref_q  <= ref_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/acm_judge.sv
`timescale 1ns/1ps
// Per-window verdict: prescale stepping, validity, stability and the reported result.
module acm_judge
  import acm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int BND_W = 9,
  parameter int TOL   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             tmo_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [BND_W-1:0] bnd_i,
  input  logic [CNT_W-1:0] vld_i,
  output ps_e              ps_o,
  output logic [CNT_W-1:0] rep_cnt_o,
  output ps_e              rep_ps_o,
  output logic             valid_o,
  output logic             stable_o
);
  localparam int CW = CNT_W + 1;

  ps_e              ps_q, ps_d, rep_ps_q;
  logic [CNT_W-1:0] rep_cnt_q, diff;
  logic             ok_q, valid_q, stable_q;
  logic             below, above, valid_d, stable_d;

  assign below = {1'b0, cnt_i} < CW'(bnd_i);
  assign above = {1'b0, cnt_i} > CW'({bnd_i, 1'b0});
  assign diff  = (cnt_i >= rep_cnt_q) ? cnt_i - rep_cnt_q : rep_cnt_q - cnt_i;

  always_comb begin
    ps_d = ps_q;
    if (tmo_i) begin
      case (ps_q)
        PS_DIV1: ps_d = PS_DIV4;
        PS_DIV2: ps_d = PS_DIV1;
        default: ps_d = PS_DIV2;
      endcase
    end else if (below) begin
      ps_d = (ps_q == PS_DIV1) ? PS_DIV2 : PS_DIV4;
    end else if (above) begin
      ps_d = (ps_q == PS_DIV4) ? PS_DIV2 : PS_DIV1;
    end
  end

  assign valid_d  = !tmo_i && (cnt_i != '0) && (cnt_i <= vld_i);
  assign stable_d = !tmo_i && ok_q && (rep_ps_q == ps_q) && (diff <= CNT_W'(TOL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_q      <= PS_DIV1;
      rep_ps_q  <= PS_DIV1;
      rep_cnt_q <= '0;
      ok_q      <= 1'b0;
      valid_q   <= 1'b0;
      stable_q  <= 1'b0;
    end else if (done_i) begin
      ps_q      <= ps_d;
      rep_ps_q  <= ps_q;
      rep_cnt_q <= cnt_i;
      ok_q      <= !tmo_i;
      valid_q   <= valid_d;
      stable_q  <= stable_d;
    end
  end

  assign ps_o      = ps_q;
  assign rep_cnt_o = rep_cnt_q;
  assign rep_ps_o  = rep_ps_q;
  assign valid_o   = valid_q;
  assign stable_o  = stable_q;
endmodule

// File: rtl/audio_clk_meter.sv
`timescale 1ns/1ps
module audio_clk_meter
  import acm_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int CNT_W    = 10,
  parameter int BND_W    = 9,
  parameter int WIN_LOG2 = 7,
  parameter int TOL      = 2,
  parameter int BND_RST  = 200,
  parameter int VLD_RST  = 1000,
  parameter int ADDR_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] meas_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int A_BND_LO = 0;
  localparam int A_BND_HI = 1;
  localparam int A_VLD_LO = 2;
  localparam int A_VLD_HI = 3;
  localparam int A_CH     = 4;
  localparam int BHI_W    = BND_W - 8;
  localparam int CHI_W    = CNT_W - 8;

  logic [BND_W-1:0] bnd_q;
  logic [CNT_W-1:0] vld_q;

  logic [NUM_CH-1:0] win_done, win_tmo, rep_valid, rep_stable;
  logic [CNT_W-1:0]  win_cnt [NUM_CH];
  logic [CNT_W-1:0]  rep_cnt [NUM_CH];
  ps_e               cur_ps  [NUM_CH];
  ps_e               rep_ps  [NUM_CH];
  logic [7:0]        stat_b  [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PS_NUM-1:0] tog_m, tog_r;

    acm_meas_div #(.W(PS_NUM)) u_div (
      .meas_clk_i(meas_clk_i[c]),
      .rst_ni    (rst_ni),
      .tog_o     (tog_m)
    );

    acm_sync #(.W(PS_NUM)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (tog_m),
      .q_o   (tog_r)
    );

    acm_window #(.CNT_W(CNT_W), .WIN_LOG2(WIN_LOG2)) u_win (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tog_i (tog_r),
      .ps_i  (cur_ps[c]),
      .done_o(win_done[c]),
      .tmo_o (win_tmo[c]),
      .cnt_o (win_cnt[c])
    );

    acm_judge #(.CNT_W(CNT_W), .BND_W(BND_W), .TOL(TOL)) u_judge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .done_i   (win_done[c]),
      .tmo_i    (win_tmo[c]),
      .cnt_i    (win_cnt[c]),
      .bnd_i    (bnd_q),
      .vld_i    (vld_q),
      .ps_o     (cur_ps[c]),
      .rep_cnt_o(rep_cnt[c]),
      .rep_ps_o (rep_ps[c]),
      .valid_o  (rep_valid[c]),
      .stable_o (rep_stable[c])
    );

    assign stat_b[c] = {rep_stable[c], rep_valid[c],
                        rep_ps[c] == PS_DIV4, rep_ps[c] == PS_DIV2,
                        {(4-CHI_W){1'b0}}, rep_cnt[c][CNT_W-1:8]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bnd_q <= BND_W'(BND_RST);
      vld_q <= CNT_W'(VLD_RST);
    end else if (wr_en_i) begin
      case (int'(addr_i))
        A_BND_LO: bnd_q[7:0]       <= wdata_i;
        A_BND_HI: bnd_q[BND_W-1:8] <= wdata_i[BHI_W-1:0];
        A_VLD_LO: vld_q[7:0]       <= wdata_i;
        A_VLD_HI: vld_q[CNT_W-1:8] <= wdata_i[CHI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (int'(addr_i))
      A_BND_LO: rdata_o = bnd_q[7:0];
      A_BND_HI: rdata_o = {{(8-BHI_W){1'b0}}, bnd_q[BND_W-1:8]};
      A_VLD_LO: rdata_o = vld_q[7:0];
      A_VLD_HI: rdata_o = {{(8-CHI_W){1'b0}}, vld_q[CNT_W-1:8]};
      default: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (int'(addr_i) == A_CH + 2*c)     rdata_o = rep_cnt[c][7:0];
          if (int'(addr_i) == A_CH + 2*c + 1) rdata_o = stat_b[c];
        end
      end
    endcase
  end
endmodule

// File: rtl/acm_checker.sv
`timescale 1ns/1ps
module acm_checker
  import acm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 10,
  parameter int BND_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] done_i,
  input logic [NUM_CH-1:0] tmo_i,
  input logic [CNT_W-1:0]  cnt_i     [NUM_CH],
  input ps_e               ps_i      [NUM_CH],
  input logic [CNT_W-1:0]  rep_cnt_i [NUM_CH],
  input ps_e               rep_ps_i  [NUM_CH],
  input logic [NUM_CH-1:0] valid_i,
  input logic [NUM_CH-1:0] stable_i,
  input logic [BND_W-1:0]  bnd_i,
  input logic [CNT_W-1:0]  vld_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_i[c] |=> $stable(rep_cnt_i[c]) && $stable(rep_ps_i[c]) &&
                     $stable(valid_i[c]) && $stable(stable_i[c]));

    p_cnt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] && !tmo_i[c] |=> rep_cnt_i[c] == $past(cnt_i[c]));

    p_tmo_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] && tmo_i[c] |=> !valid_i[c] && !stable_i[c] && (&rep_cnt_i[c]));

    p_tmo_rotate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] && tmo_i[c] && ps_i[c] == PS_DIV1 |=> ps_i[c] == PS_DIV4);

    p_step_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] && !tmo_i[c] && int'(cnt_i[c]) < int'(bnd_i) && ps_i[c] == PS_DIV1
      |=> ps_i[c] == PS_DIV2);

    p_step_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] && !tmo_i[c] && int'(cnt_i[c]) > 2*int'(bnd_i) && ps_i[c] == PS_DIV4
      |=> ps_i[c] == PS_DIV2);

    p_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] && !tmo_i[c] && cnt_i[c] != '0 && int'(cnt_i[c]) <= int'(vld_i)
      |=> valid_i[c]);

    p_ps_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[c] && ps_i[c] != rep_ps_i[c] |=> !stable_i[c]);
  end
endmodule

bind audio_clk_meter acm_checker #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W),
  .BND_W (BND_W)
) u_acm_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_i   (win_done),
  .tmo_i    (win_tmo),
  .cnt_i    (win_cnt),
  .ps_i     (cur_ps),
  .rep_cnt_i(rep_cnt),
  .rep_ps_i (rep_ps),
  .valid_i  (rep_valid),
  .stable_i (rep_stable),
  .bnd_i    (bnd_q),
  .vld_i    (vld_q)
);

// File: tb/tb_audio_clk_meter.sv
`timescale 1ns/1ps
module tb_audio_clk_meter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m0 = 1'b0, m1 = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int      checks = 0, errors = 0;
  bit      finished = 0;
  realtime half0 = 25.0, half1 = 50.0;
  bit      run0 = 1, run1 = 1;

  audio_clk_meter dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .meas_clk_i({m1, m0}),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata)
  );

  always #10 clk = ~clk;

  // Measured clocks start off-grid so their edges never meet reference edges.
  initial begin
    #3.3;
    forever begin
      if (run0) begin m0 = ~m0; #(half0); end
      else #7;
    end
  end

  initial begin
    #3.8;
    forever begin
      if (run1) begin m1 = ~m1; #(half1); end
      else #7;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_ch(input int c, output int cnt, output logic [7:0] st);
    logic [7:0] lo;
    @(negedge clk);
    addr = 4'(4 + 2*c);
    #1 lo = rdata;
    addr = 4'(5 + 2*c);
    #1 st = rdata;
    cnt = {st[1:0], lo};
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Steady prescale implied by the stepping rule (R5) for a period ratio tm/20.
  function automatic int exp_ps(input int tm, input int bnd);
    for (int p = 1; p <= 4; p = p * 2) begin
      int c10 = 64 * p * tm;
      if (c10 <= 10230 && !(c10 < bnd*10 && p < 4) && !(c10 > 2*bnd*10 && p > 1))
        return p;
    end
    return 0;
  endfunction

  task automatic check_ch(input int c, input int tm, input int bnd, input int vthr);
    int cnt, p, e10, enc;
    logic [7:0] st;
    p   = exp_ps(tm, bnd);
    e10 = 64 * p * tm;
    enc = (p == 4) ? 2 : (p == 2) ? 1 : 0;
    rd_ch(c, cnt, st);
    chk((cnt*10 >= e10 - 10) && (cnt*10 <= e10 + 10), "R3 count", cnt, e10/10);
    chk(int'(st[5:4]) == enc, "R5 prescale", int'(st[5:4]), enc);
    chk(st[3:2] == 2'b00 && st[5:4] != 2'b11, "R4 status layout", int'(st), enc << 4);
    chk(st[6] == (cnt != 0 && cnt <= vthr), "R6 valid", int'(st[6]), int'(cnt != 0 && cnt <= vthr));
    chk(st[7] == 1'b1, "R8 stable", int'(st[7]), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, st;
    int cnt;
    int tm0_l[8] = '{50, 30, 10, 100, 33, 25, 150, 40};
    int tm1_l[8] = '{100, 10, 33, 50, 40, 150, 30, 25};
    logic [7:0] rst_exp[8] = '{8'hC8, 8'h00, 8'hE8, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00};
    bit poll_ok;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d);
      chk(d == rst_exp[a], "R1 reset", int'(d), int'(rst_exp[a]));
    end

    // R2 field widths and readback
    wr(4'd1, 8'hFF); rd(4'd1, d); chk(d == 8'h01, "R2 bnd hi", int'(d), 1);
    wr(4'd3, 8'hFE); rd(4'd3, d); chk(d == 8'h02, "R2 vld hi", int'(d), 2);
    wr(4'd0, 8'h5A); rd(4'd0, d); chk(d == 8'h5A, "R2 bnd lo", int'(d), 'h5A);
    wr(4'd2, 8'hA5); rd(4'd2, d); chk(d == 8'hA5, "R2 vld lo", int'(d), 'hA5);
    wr(4'd0, 8'hC8); wr(4'd1, 8'h00); wr(4'd2, 8'hE8); wr(4'd3, 8'h03);

    // Sweep of period ratios on both channels (R3 R4 R5 R6 R8; R7 via 10 ns start at divide-by-1)
    for (int i = 0; i < 8; i++) begin
      half0 = tm0_l[i] / 2.0;
      half1 = tm1_l[i] / 2.0;
      wait_cyc(8000);
      check_ch(0, tm0_l[i], 200, 1000);
      check_ch(1, tm1_l[i], 200, 1000);
    end

    // R6 boundary: exact count 320 against a threshold at and just below it
    half0 = 25.0; half1 = 25.0;
    wait_cyc(8000);
    wr(4'd2, 8'h40); wr(4'd3, 8'h01);
    wait_cyc(2500);
    rd_ch(0, cnt, st);
    chk(st[6] == 1'b1 && cnt == 320, "R6 at threshold", int'(st[6]), 1);
    wr(4'd2, 8'h3F);
    wait_cyc(2500);
    rd_ch(0, cnt, st);
    chk(st[6] == 1'b0 && cnt == 320, "R6 above threshold", int'(st[6]), 0);
    wr(4'd2, 8'hE8); wr(4'd3, 8'h03);
    wait_cyc(2500);

    // R9 count and status always read as a consistent pair
    poll_ok = 1;
    for (int k = 0; k < 2000; k++) begin
      rd_ch(0, cnt, st);
      if (cnt != 320 || st != 8'hC1) poll_ok = 0;
    end
    chk(poll_ok, "R9 paired update", int'(poll_ok), 1);

    // R5 with a lowered boundary
    half0 = 15.0; half1 = 12.5;
    wr(4'd0, 8'd100);
    wait_cyc(8000);
    check_ch(0, 30, 100, 1000);
    check_ch(1, 25, 100, 1000);
    wr(4'd0, 8'd200);
    wait_cyc(8000);
    check_ch(0, 30, 200, 1000);

    // R7 missing clock on channel 1; R10 channel 0 unaffected
    run1 = 0;
    wait_cyc(6000);
    rd_ch(1, cnt, st);
    chk(cnt == 1023, "R7 timeout count", cnt, 1023);
    chk(st[7:6] == 2'b00, "R7 timeout flags", int'(st[7:6]), 0);
    check_ch(0, 30, 200, 1000);
    rd_ch(0, cnt, st);
    chk(st[7:6] == 2'b11, "R10 other channel", int'(st[7:6]), 3);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule